// File: doc/BRIEF.md
# Scoreboarded Dispatch Queue with Late Operand Read

This block sits between instruction decode and one execution unit. Decode offers one instruction per cycle, made of an opcode, two source register numbers and a destination register number. An accepted instruction goes into a small holding queue that stores only those numbers. At the same moment, a per-register scoreboard marks the destination as pending.

Each cycle the queue looks for entries whose sources are both available. It sends the oldest such entry to the execution unit. The operand values are read from the register file only at that point, so the queue never holds data. When the execution unit returns a result, the register file is written and the scoreboard marks that register available again.

Issue is held back when the queue is full or when accepting the instruction would overwrite a register that is still pending or still needed by a waiting entry. Register 0 is a constant zero and is never pending.

Top module: `sb_dispatch`

## Requirements
- R1: After reset the queue is empty, every register is marked available, `iss_ready` is high and `dsp_valid` is low.
- R2: An accepted issue with a nonzero destination marks that register pending. Any later instruction that reads it waits until a writeback to it. If an issue and a writeback name the same register in one cycle, the register ends up pending.
- R3: The queue holds up to 4 instructions, and `iss_ready` is low while all 4 slots are occupied.
- R4: An entry may dispatch when each of its sources meets at least one of these conditions: it is register 0, it is available, it is being written back in that same cycle, or it equals the entry's own destination. Dispatch outputs appear on the cycle after that check, and the operand values are those read at the check, with same-cycle writeback data forwarded.
- R5: At most one instruction dispatches per cycle, and among ready entries the one issued earliest goes first.
- R6: A writeback (`wb_valid`) to a nonzero register stores `wb_data` and marks the register available.
- R7: Register 0 always reads as zero, is always available, and ignores writebacks and issues that name it as destination.
- R8: `iss_ready` is low while the offered destination (nonzero) is pending and not being written back in that cycle.
- R9: `iss_ready` is low while any occupied queue entry names the offered nonzero destination as one of its sources.
- R10: `dsp_op` and `dsp_rd` carry the opcode and destination number stored at issue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Decode offers an instruction |
| iss_op | input | 6 | Opcode of the offered instruction |
| iss_rs1 | input | 4 | First source register number |
| iss_rs2 | input | 4 | Second source register number |
| iss_rd | input | 4 | Destination register number |
| iss_ready | output | 1 | Offered instruction is accepted this cycle |
| wb_valid | input | 1 | Result returning from the execution unit |
| wb_rd | input | 4 | Register the result is written to |
| wb_data | input | 32 | Result value |
| dsp_valid | output | 1 | Instruction sent to the execution unit this cycle |
| dsp_op | output | 6 | Opcode of the sent instruction |
| dsp_a | output | 32 | First operand value |
| dsp_b | output | 32 | Second operand value |
| dsp_rd | output | 4 | Destination register of the sent instruction |

## Verification
A writeback and the readiness check of a waiting entry can fall in the same cycle. The bench provokes this by holding an entry on a pending source and then returning that register's result. It judges the case by requiring `dsp_valid` on the very next cycle, with the forwarded value as the operand. Issue and writeback can also name the same register in one cycle. The bench drives both together and then shows that a later reader of that register is held until a second writeback, whose value it must receive.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned DEF_NREG  = 16;
  localparam int unsigned DEF_XLEN  = 32;
  localparam int unsigned DEF_DEPTH = 4;
  localparam int unsigned DEF_OPW   = 6;

  // index width helper that never returns zero
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sbd_regfile.sv
module sbd_regfile #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int RIW = sbd_pkg::idx_w(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIW-1:0]  wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RIW-1:0]  ra0,
  input  logic [RIW-1:0]  ra1,
  output logic [XLEN-1:0] rd0,
  output logic [XLEN-1:0] rd1
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  // asynchronous read (distributed RAM) with write-through forwarding
  always_comb begin
    if (ra0 == '0)             rd0 = '0;
    else if (we && wa == ra0)  rd0 = wd;
    else                       rd0 = mem[ra0];
    if (ra1 == '0)             rd1 = '0;
    else if (we && wa == ra1)  rd1 = wd;
    else                       rd1 = mem[ra1];
  end
endmodule

// File: rtl/sbd_scoreboard.sv
module sbd_scoreboard #(
  parameter int NREG = 16,
  localparam int RIW = sbd_pkg::idx_w(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_en,
  input  logic [RIW-1:0]  clr_idx,
  input  logic            set_en,
  input  logic [RIW-1:0]  set_idx,
  output logic [NREG-1:0] ok_vec
);
  logic [NREG-1:0] avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail <= '1;
    end else begin
      if (set_en) avail[set_idx] <= 1'b1;
      if (clr_en) avail[clr_idx] <= 1'b0;  // younger issue wins
      avail[0] <= 1'b1;
    end
  end

  // availability as seen this cycle, including a result arriving now
  always_comb begin
    ok_vec = avail;
    if (set_en) ok_vec[set_idx] = 1'b1;
    ok_vec[0] = 1'b1;
  end

  assert_clear_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_idx != '0) |=> !avail[$past(clr_idx)]);

  assert_wb_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (set_en && set_idx != '0 && !(clr_en && clr_idx == set_idx)) |=> avail[$past(set_idx)]);
endmodule

// File: rtl/sbd_station.sv
module sbd_station #(
  parameter int NREG  = 16,
  parameter int DEPTH = 4,
  parameter int OPW   = 6,
  localparam int RIW  = sbd_pkg::idx_w(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [OPW-1:0]  push_op,
  input  logic [RIW-1:0]  push_rs1,
  input  logic [RIW-1:0]  push_rs2,
  input  logic [RIW-1:0]  push_rd,
  input  logic [NREG-1:0] src_ok,
  input  logic [RIW-1:0]  chk_rd,
  output logic            has_space,
  output logic            war_hit,
  output logic            pick_vld,
  output logic [OPW-1:0]  pick_op,
  output logic [RIW-1:0]  pick_rs1,
  output logic [RIW-1:0]  pick_rs2,
  output logic [RIW-1:0]  pick_rd
);
  localparam int CW = sbd_pkg::idx_w(DEPTH + 1);
  localparam int IW = sbd_pkg::idx_w(DEPTH);

  // slot 0 holds the oldest entry; slots below count are occupied
  logic [OPW-1:0] e_op  [DEPTH];
  logic [RIW-1:0] e_rs1 [DEPTH];
  logic [RIW-1:0] e_rs2 [DEPTH];
  logic [RIW-1:0] e_rd  [DEPTH];
  logic [OPW-1:0] n_op  [DEPTH];
  logic [RIW-1:0] n_rs1 [DEPTH];
  logic [RIW-1:0] n_rs2 [DEPTH];
  logic [RIW-1:0] n_rd  [DEPTH];
  logic [CW-1:0]  count, cnt_after;
  logic [DEPTH-1:0] rdy;
  logic [IW-1:0]  pidx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rdy[i] = (CW'(i) < count)
             && (src_ok[e_rs1[i]] || e_rs1[i] == e_rd[i])
             && (src_ok[e_rs2[i]] || e_rs2[i] == e_rd[i]);
    end
  end

  always_comb begin
    pick_vld = 1'b0;
    pidx     = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rdy[i]) begin
        pick_vld = 1'b1;
        pidx     = IW'(i);
      end
    end
  end

  assign pick_op  = e_op[pidx];
  assign pick_rs1 = e_rs1[pidx];
  assign pick_rs2 = e_rs2[pidx];
  assign pick_rd  = e_rd[pidx];

  always_comb begin
    war_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < count && chk_rd != '0 && (e_rs1[i] == chk_rd || e_rs2[i] == chk_rd))
        war_hit = 1'b1;
    end
  end

  assign has_space = count < CW'(DEPTH);
  assign cnt_after = count - CW'(pick_vld);

  // remove the picked slot, close the gap, append the new entry at the tail
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_op[i]  = e_op[i];
      n_rs1[i] = e_rs1[i];
      n_rs2[i] = e_rs2[i];
      n_rd[i]  = e_rd[i];
      if (pick_vld && IW'(i) >= pidx && i < DEPTH - 1) begin
        n_op[i]  = e_op[i+1];
        n_rs1[i] = e_rs1[i+1];
        n_rs2[i] = e_rs2[i+1];
        n_rd[i]  = e_rd[i+1];
      end
      if (push && CW'(i) == cnt_after) begin
        n_op[i]  = push_op;
        n_rs1[i] = push_rs1;
        n_rs2[i] = push_rs2;
        n_rd[i]  = push_rd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= cnt_after + CW'(push);
  end

  always_ff @(posedge clk) begin
    e_op  <= n_op;
    e_rs1 <= n_rs1;
    e_rs2 <= n_rs2;
    e_rd  <= n_rd;
  end

  assert_push_has_room_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && !push) |=> (count == $past(count) - CW'(1)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!pick_vld && !push) |=> $stable(count));
endmodule

// File: rtl/sb_dispatch.sv
module sb_dispatch
  import sbd_pkg::*;
#(
  parameter int NREG  = DEF_NREG,
  parameter int XLEN  = DEF_XLEN,
  parameter int DEPTH = DEF_DEPTH,
  parameter int OPW   = DEF_OPW,
  localparam int RIW  = idx_w(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [OPW-1:0]  iss_op,
  input  logic [RIW-1:0]  iss_rs1,
  input  logic [RIW-1:0]  iss_rs2,
  input  logic [RIW-1:0]  iss_rd,
  output logic            iss_ready,
  input  logic            wb_valid,
  input  logic [RIW-1:0]  wb_rd,
  input  logic [XLEN-1:0] wb_data,
  output logic            dsp_valid,
  output logic [OPW-1:0]  dsp_op,
  output logic [XLEN-1:0] dsp_a,
  output logic [XLEN-1:0] dsp_b,
  output logic [RIW-1:0]  dsp_rd
);
  logic [NREG-1:0] sb_ok;
  logic            st_space, st_war, iss_fire;
  logic            pk_vld;
  logic [OPW-1:0]  pk_op;
  logic [RIW-1:0]  pk_rs1, pk_rs2, pk_rd;
  logic [XLEN-1:0] op_a, op_b;

  assign iss_ready = st_space && !st_war && sb_ok[iss_rd];
  assign iss_fire  = iss_valid && iss_ready;

  sbd_scoreboard #(.NREG(NREG)) u_sb (
    .clk(clk), .rst(rst),
    .clr_en(iss_fire), .clr_idx(iss_rd),
    .set_en(wb_valid), .set_idx(wb_rd),
    .ok_vec(sb_ok)
  );

  sbd_station #(.NREG(NREG), .DEPTH(DEPTH), .OPW(OPW)) u_st (
    .clk(clk), .rst(rst),
    .push(iss_fire), .push_op(iss_op), .push_rs1(iss_rs1),
    .push_rs2(iss_rs2), .push_rd(iss_rd),
    .src_ok(sb_ok), .chk_rd(iss_rd),
    .has_space(st_space), .war_hit(st_war),
    .pick_vld(pk_vld), .pick_op(pk_op), .pick_rs1(pk_rs1),
    .pick_rs2(pk_rs2), .pick_rd(pk_rd)
  );

  sbd_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk(clk), .we(wb_valid), .wa(wb_rd), .wd(wb_data),
    .ra0(pk_rs1), .ra1(pk_rs2), .rd0(op_a), .rd1(op_b)
  );

  always_ff @(posedge clk) begin
    if (rst) dsp_valid <= 1'b0;
    else     dsp_valid <= pk_vld;
  end

  always_ff @(posedge clk) begin
    if (pk_vld) begin
      dsp_op <= pk_op;
      dsp_a  <= op_a;
      dsp_b  <= op_b;
      dsp_rd <= pk_rd;
    end
  end

  assert_dispatch_follows_pick_R5: assert property (@(posedge clk) disable iff (rst)
    pk_vld |=> dsp_valid);
endmodule

// File: tb/sim_sb_dispatch.sv
module sim_sb_dispatch;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic [5:0]  iss_op;
  logic [3:0]  iss_rs1, iss_rs2, iss_rd;
  logic        iss_ready;
  logic        wb_valid;
  logic [3:0]  wb_rd;
  logic [31:0] wb_data;
  logic        dsp_valid;
  logic [5:0]  dsp_op;
  logic [31:0] dsp_a, dsp_b;
  logic [3:0]  dsp_rd;

  typedef logic [73:0] exp_t;
  exp_t        expq[$];
  logic [31:0] mrf[16];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sb_dispatch u0 (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_rs1(iss_rs1),
    .iss_rs2(iss_rs2), .iss_rd(iss_rd), .iss_ready(iss_ready),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_a(dsp_a),
    .dsp_b(dsp_b), .dsp_rd(dsp_rd)
  );

  function automatic logic [31:0] rv(int r);
    return (r == 0) ? 32'd0 : mrf[r];
  endfunction

  function automatic exp_t mk(int op, logic [31:0] a, logic [31:0] b, int rd);
    return {6'(op), a, b, 4'(rd)};
  endfunction

  task automatic chk(bit ok, string tag, exp_t act, exp_t exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every dispatch must match the head of the expected queue
  always @(posedge clk) begin : mon
    exp_t got;
    exp_t e;
    #1;
    if (!rst && dsp_valid) begin
      got = {dsp_op, dsp_a, dsp_b, dsp_rd};
      if (expq.size() == 0) chk(1'b0, "R5 dispatch while nothing is due", got, '0);
      else begin
        e = expq.pop_front();
        chk(got == e, "R4 R10 dispatch order and fields", got, e);
      end
    end
  end

  task automatic issue(int op, int rd, int rs1, int rs2, bit due);
    iss_valid = 1'b1; iss_op = 6'(op); iss_rd = 4'(rd);
    iss_rs1 = 4'(rs1); iss_rs2 = 4'(rs2);
    #1;
    chk(iss_ready, "R3 R8 R9 issue accepted", exp_t'(iss_ready), 1);
    if (due) expq.push_back(mk(op, rv(rs1), rv(rs2), rd));
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic wb(int r, logic [31:0] v);
    wb_valid = 1'b1; wb_rd = 4'(r); wb_data = v;
    if (r != 0) mrf[r] = v;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic probe_ready(int rd, bit exp, string tag);
    iss_rd = 4'(rd); iss_rs1 = 4'd1; iss_rs2 = 4'd1;
    #1;
    chk(iss_ready == exp, tag, exp_t'(iss_ready), exp_t'(exp));
  endtask

  task automatic drain();
    int k = 0;
    while (expq.size() != 0 && k < 200) begin
      @(negedge clk);
      k++;
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5 expected dispatch missing", exp_t'(expq.size()), 0);
  endtask

  task automatic restore();
    for (int r = 1; r < 16; r++) wb(r, 32'h100 + r);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; iss_valid = 1'b0; iss_op = '0; iss_rs1 = '0; iss_rs2 = '0;
    iss_rd = '0; wb_valid = 1'b0; wb_rd = '0; wb_data = '0;
    for (int r = 0; r < 16; r++) mrf[r] = '0;
    repeat (3) @(negedge clk);
    chk(!dsp_valid, "R1 dispatch idle in reset", exp_t'(dsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    probe_ready(3, 1'b1, "R1 ready after reset");
    chk(!dsp_valid, "R1 no dispatch after reset", exp_t'(dsp_valid), 0);
    restore();

    // R4 R6: plain dispatch, then a dependent waiting on a pending source
    issue(1, 3, 1, 2, 1'b1);
    drain();
    issue(2, 4, 3, 0, 1'b0);
    repeat (3) @(negedge clk);
    expq.push_back(mk(2, 32'hAAA, 32'd0, 4));
    wb(3, 32'hAAA);
    chk(dsp_valid, "R4 same-cycle writeback seen by check", exp_t'(dsp_valid), 1);
    drain();
    restore();

    // R5: a later ready instruction overtakes waiting ones, waiters leave oldest first
    issue(20, 5, 1, 1, 1'b1);
    issue(21, 6, 5, 2, 1'b0);
    issue(22, 7, 5, 3, 1'b0);
    issue(23, 8, 1, 2, 1'b1);
    repeat (2) @(negedge clk);
    expq.push_back(mk(21, 32'h555, rv(2), 6));
    expq.push_back(mk(22, 32'h555, rv(3), 7));
    wb(5, 32'h555);
    drain();
    restore();

    // R4: source equal to own destination does not block
    issue(24, 5, 5, 1, 1'b1);
    drain();
    restore();

    // R3: full queue refuses issue
    issue(30, 9, 1, 1, 1'b1);
    for (int k = 0; k < 4; k++) issue(31 + k, 10 + k, 9, 2, 1'b0);
    iss_valid = 1'b1; iss_op = 6'd40; iss_rd = 4'd14; iss_rs1 = 4'd1; iss_rs2 = 4'd1;
    #1;
    chk(!iss_ready, "R3 full queue stalls issue", exp_t'(iss_ready), 0);
    repeat (2) @(negedge clk);
    iss_valid = 1'b0;
    for (int k = 0; k < 4; k++) expq.push_back(mk(31 + k, 32'h999, rv(2), 10 + k));
    wb(9, 32'h999);
    drain();
    restore();

    // R8 R9: pending destination and waiting reader block issue
    issue(41, 9, 1, 1, 1'b1);
    issue(42, 14, 9, 2, 1'b0);
    @(negedge clk);
    probe_ready(9, 1'b0, "R8 pending destination stalls issue");
    probe_ready(2, 1'b0, "R9 destination read by waiting entry stalls issue");
    probe_ready(3, 1'b1, "R9 unrelated destination accepted");
    expq.push_back(mk(42, 32'h777, rv(2), 14));
    wb(9, 32'h777);
    drain();
    restore();

    // R2: issue and writeback to the same register in one cycle
    iss_valid = 1'b1; iss_op = 6'd8; iss_rd = 4'd15; iss_rs1 = 4'd1; iss_rs2 = 4'd2;
    wb_valid = 1'b1; wb_rd = 4'd15; wb_data = 32'h1234;
    #1;
    chk(iss_ready, "R2 issue alongside writeback accepted", exp_t'(iss_ready), 1);
    expq.push_back(mk(8, rv(1), rv(2), 15));
    mrf[15] = 32'h1234;
    @(negedge clk);
    iss_valid = 1'b0; wb_valid = 1'b0;
    issue(9, 4, 15, 0, 1'b0);
    repeat (4) @(negedge clk);
    expq.push_back(mk(9, 32'h55, 32'd0, 4));
    wb(15, 32'h55);
    drain();
    restore();

    // R7: register 0 stays zero and available
    wb(0, 32'hDEAD);
    issue(50, 0, 1, 2, 1'b1);
    issue(51, 5, 0, 0, 1'b1);
    issue(52, 0, 0, 3, 1'b1);
    drain();
    probe_ready(0, 1'b1, "R7 register 0 never pending");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule